// File: doc/BRIEF.md
# RV32I Instruction Decoder with Arithmetic-Unit Select

This block is a purely combinational decoder for one 32-bit base-integer instruction word. It cuts the word into its register and function fields and builds the sign-extended immediate for the word's format. It flags the instruction class from the major opcode, with the immediate class split three ways: loads, immediate arithmetic and the indirect jump. It then names the exact instruction on a 30-bit one-hot vector.

The same vector produces a 4-bit code that tells a downstream arithmetic unit which operation to perform. Each indicator bit gates its instruction's unit code, or zero, and all gated values are summed. Because at most one indicator is high, the sum is the code of the matched instruction. Any word outside the supported set leaves every indicator low, drives code 0000 and raises an illegal flag.

The block has no clock and no state. A pipeline places it between instruction fetch and the register-read and execute stages.

Top module: `instr_decode`

## Requirements
- R1: The fields come from fixed bit positions in every format: opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20] and funct7 [31:25].
- R2: `typeVec` follows the opcode alone, one bit per class. Bit 0 is register (0110011), bit 1 load (0000011), bit 2 immediate arithmetic (0010011), bit 3 indirect jump (1100111), bit 4 store (0100011), bit 5 branch (1100011), bit 6 upper-immediate (0110111) and bit 7 direct jump (1101111). An unknown opcode leaves all eight bits low. A known opcode with an unsupported funct3/funct7 still raises its class bit.
- R3: Register class, funct7 0000000: funct3 000 add, 001 sll, 010 slt, 011 sltu, 100 xor, 101 srl, 110 or, 111 and. With funct7 0100000, funct3 000 is sub and 101 is sra. Every other funct7 is unsupported.
- R4: Immediate-arithmetic class: funct3 000 addi, 010 slti, 011 sltiu, 100 xori, 110 ori, 111 andi, whatever the upper bits hold. Funct3 001 is slli only with funct7 0000000. Funct3 101 is srli with funct7 0000000 and srai with 0100000.
- R5: Loads use funct3 000 lb, 001 lh, 010 lw. Stores use 000 sb, 001 sh, 010 sw. Branches use 000 beq, 001 bne. The indirect jump needs funct3 000. The upper-immediate and direct-jump classes each map to one instruction (lui, jal) with no further fields.
- R6: `instrHot` bit order is 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 sll, 6 srl, 7 sra, 8 slt, 9 sltu, 10 addi, 11 andi, 12 ori, 13 xori, 14 slli, 15 srli, 16 srai, 17 slti, 18 sltiu, 19 lb, 20 lh, 21 lw, 22 jalr, 23 sb, 24 sh, 25 sw, 26 beq, 27 bne, 28 lui, 29 jal. A supported word raises exactly one bit.
- R7: `aluSel` codes are add 0000, and 0001, or 0010, xor 0011, sll 0100, srl 0101, sra 0110, slt 0111, sltu 1000, sub 1001, pass-B 1010, equal 1011 and not-equal 1100. Immediate forms share their register form's code. Loads, stores, jalr and jal use add, lui uses pass-B, beq uses equal and bne uses not-equal.
- R8: An unsupported word drives all of `instrHot` low, `aluSel` to 0000 and `illegal` high. `illegal` is low for every supported word.
- R9: Load, immediate-arithmetic and indirect-jump words yield imm = sign-extend(word[31:20]). Store words yield imm = sign-extend({word[31:25], word[11:7]}).
- R10: Branch words yield the sign-extended 13-bit offset {word[31], word[7], word[30:25], word[11:8], 0}. Direct-jump words yield the sign-extended 21-bit offset {word[31], word[19:12], word[20], word[30:21], 0}. Bit 0 is zero in both cases.
- R11: Upper-immediate words yield {word[31:12], 12'b0}. Register-class words and words with an unknown opcode yield imm = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| opcode | output | 7 | Major opcode field |
| rd | output | 5 | Destination register field |
| funct3 | output | 3 | Minor function field |
| rs1 | output | 5 | First source register field |
| rs2 | output | 5 | Second source register field |
| funct7 | output | 7 | Upper function field |
| imm | output | 32 | Sign-extended immediate for the word's format |
| typeVec | output | 8 | Instruction class flags |
| instrHot | output | 30 | One-hot exact-instruction indicator |
| aluSel | output | 4 | Arithmetic unit select code |
| illegal | output | 1 | Word is outside the supported set |

## Verification
The decoder holds no state, so any fault shows at the ports in the same evaluation as the word that exposes it. A wrong funct3/funct7 match shows up on two ports at once: a shifted or missing bit in `instrHot`, and a wrong code in `aluSel`. A wrong gate value in the sum changes `aluSel` only for the one instruction that owns that gate, so every one of the 30 instructions is driven several times. Illegal words are picked to sit one field away from a supported encoding, so that each funct3/funct7 qualifier must actually reject them.

// File: rtl/instr_decode_pkg.sv
package instr_decode_pkg;

  localparam int XLEN      = 32;
  localparam int NUM_INSTR = 30;
  localparam int NUM_TYPES = 8;
  localparam int SEL_W     = 4;
  localparam int ACC_W     = SEL_W + $clog2(NUM_INSTR);

  localparam logic [6:0] OP_REG  = 7'b0110011;
  localparam logic [6:0] OP_LOAD = 7'b0000011;
  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_JALR = 7'b1100111;
  localparam logic [6:0] OP_STOR = 7'b0100011;
  localparam logic [6:0] OP_BRAN = 7'b1100011;
  localparam logic [6:0] OP_LUI  = 7'b0110111;
  localparam logic [6:0] OP_JAL  = 7'b1101111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [SEL_W-1:0] {
    ALU_ADD = 4'd0, ALU_AND = 4'd1, ALU_OR = 4'd2, ALU_XOR = 4'd3,
    ALU_SLL = 4'd4, ALU_SRL = 4'd5, ALU_SRA = 4'd6, ALU_SLT = 4'd7,
    ALU_SLTU = 4'd8, ALU_SUB = 4'd9, ALU_PASSB = 4'd10, ALU_EQ = 4'd11,
    ALU_NE = 4'd12
  } alu_code_e;

  typedef enum int {
    IX_ADD = 0, IX_SUB, IX_AND, IX_OR, IX_XOR, IX_SLL, IX_SRL, IX_SRA,
    IX_SLT, IX_SLTU, IX_ADDI, IX_ANDI, IX_ORI, IX_XORI, IX_SLLI, IX_SRLI,
    IX_SRAI, IX_SLTI, IX_SLTIU, IX_LB, IX_LH, IX_LW, IX_JALR, IX_SB,
    IX_SH, IX_SW, IX_BEQ, IX_BNE, IX_LUI, IX_JAL
  } instr_ix_e;

  // Class strobes handed from control to the field datapath; r is bit 0.
  typedef struct packed {
    logic uj;
    logic u;
    logic sb;
    logic s;
    logic jalr;
    logic iop;
    logic load;
    logic r;
  } type_strobes_t;

  function automatic alu_code_e unitOf(input int ix);
    case (ix)
      IX_SUB:                   return ALU_SUB;
      IX_AND, IX_ANDI:          return ALU_AND;
      IX_OR, IX_ORI:            return ALU_OR;
      IX_XOR, IX_XORI:          return ALU_XOR;
      IX_SLL, IX_SLLI:          return ALU_SLL;
      IX_SRL, IX_SRLI:          return ALU_SRL;
      IX_SRA, IX_SRAI:          return ALU_SRA;
      IX_SLT, IX_SLTI:          return ALU_SLT;
      IX_SLTU, IX_SLTIU:        return ALU_SLTU;
      IX_LUI:                   return ALU_PASSB;
      IX_BEQ:                   return ALU_EQ;
      IX_BNE:                   return ALU_NE;
      default:                  return ALU_ADD;
    endcase
  endfunction

endpackage

// File: rtl/instr_decode_fields.sv
module instr_decode_fields
  import instr_decode_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  input  type_strobes_t   strobes,
  output logic [6:0]      opcode,
  output logic [4:0]      rd,
  output logic [2:0]      funct3,
  output logic [4:0]      rs1,
  output logic [4:0]      rs2,
  output logic [6:0]      funct7,
  output logic [XLEN-1:0] imm
);

  // Shared fields: same position in every format.
  assign opcode = instr[6:0];
  assign rd     = instr[11:7];
  assign funct3 = instr[14:12];
  assign rs1    = instr[19:15];
  assign rs2    = instr[24:20];
  assign funct7 = instr[31:25];

  logic [XLEN-1:0] immI, immS, immB, immU, immJ;

  assign immI = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign immS = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
  assign immB = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25],
                 instr[11:8], 1'b0};
  assign immU = {instr[31:12], 12'b0};
  assign immJ = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12], instr[20],
                 instr[30:21], 1'b0};

  always_comb begin
    imm = '0;
    if (strobes.load || strobes.iop || strobes.jalr) imm = immI;
    else if (strobes.s)  imm = immS;
    else if (strobes.sb) imm = immB;
    else if (strobes.u)  imm = immU;
    else if (strobes.uj) imm = immJ;
  end

  always_comb begin
    p_offset_even_r10: assert (!(strobes.sb || strobes.uj) || !imm[0])
      else $error("branch/jump offset has bit 0 set");
    p_upper_low_zero_r11: assert (!strobes.u || imm[11:0] == 12'b0)
      else $error("upper immediate low bits not zero");
    p_no_class_no_imm_r11: assert ((strobes != '0 && !strobes.r) || imm == '0)
      else $error("immediate nonzero without immediate class");
  end

endmodule

// File: rtl/instr_decode_ctrl.sv
module instr_decode_ctrl
  import instr_decode_pkg::*;
(
  input  logic [6:0]           opcode,
  input  logic [2:0]           funct3,
  input  logic [6:0]           funct7,
  output type_strobes_t        strobes,
  output logic [NUM_INSTR-1:0] instrHot,
  output logic [SEL_W-1:0]     aluSel,
  output logic                 illegal
);

  // Class from the opcode alone.
  always_comb begin
    strobes = '0;
    case (opcode)
      OP_REG:  strobes.r    = 1'b1;
      OP_LOAD: strobes.load = 1'b1;
      OP_IMM:  strobes.iop  = 1'b1;
      OP_JALR: strobes.jalr = 1'b1;
      OP_STOR: strobes.s    = 1'b1;
      OP_BRAN: strobes.sb   = 1'b1;
      OP_LUI:  strobes.u    = 1'b1;
      OP_JAL:  strobes.uj   = 1'b1;
      default: strobes      = '0;
    endcase
  end

  // Exact instruction from class, funct3 and funct7.
  always_comb begin
    instrHot = '0;
    if (strobes.r) begin
      if (funct7 == F7_BASE) begin
        case (funct3)
          3'b000: instrHot[IX_ADD]  = 1'b1;
          3'b001: instrHot[IX_SLL]  = 1'b1;
          3'b010: instrHot[IX_SLT]  = 1'b1;
          3'b011: instrHot[IX_SLTU] = 1'b1;
          3'b100: instrHot[IX_XOR]  = 1'b1;
          3'b101: instrHot[IX_SRL]  = 1'b1;
          3'b110: instrHot[IX_OR]   = 1'b1;
          default: instrHot[IX_AND] = 1'b1;
        endcase
      end else if (funct7 == F7_ALT) begin
        if (funct3 == 3'b000) instrHot[IX_SUB] = 1'b1;
        if (funct3 == 3'b101) instrHot[IX_SRA] = 1'b1;
      end
    end
    if (strobes.iop) begin
      case (funct3)
        3'b000: instrHot[IX_ADDI]  = 1'b1;
        3'b010: instrHot[IX_SLTI]  = 1'b1;
        3'b011: instrHot[IX_SLTIU] = 1'b1;
        3'b100: instrHot[IX_XORI]  = 1'b1;
        3'b110: instrHot[IX_ORI]   = 1'b1;
        3'b111: instrHot[IX_ANDI]  = 1'b1;
        3'b001: instrHot[IX_SLLI]  = (funct7 == F7_BASE);
        default: begin
          instrHot[IX_SRLI] = (funct7 == F7_BASE);
          instrHot[IX_SRAI] = (funct7 == F7_ALT);
        end
      endcase
    end
    if (strobes.load) begin
      instrHot[IX_LB] = (funct3 == 3'b000);
      instrHot[IX_LH] = (funct3 == 3'b001);
      instrHot[IX_LW] = (funct3 == 3'b010);
    end
    if (strobes.jalr) instrHot[IX_JALR] = (funct3 == 3'b000);
    if (strobes.s) begin
      instrHot[IX_SB] = (funct3 == 3'b000);
      instrHot[IX_SH] = (funct3 == 3'b001);
      instrHot[IX_SW] = (funct3 == 3'b010);
    end
    if (strobes.sb) begin
      instrHot[IX_BEQ] = (funct3 == 3'b000);
      instrHot[IX_BNE] = (funct3 == 3'b001);
    end
    if (strobes.u)  instrHot[IX_LUI] = 1'b1;
    if (strobes.uj) instrHot[IX_JAL] = 1'b1;
  end

  // Gate each indicator onto its unit code, then sum.
  logic [SEL_W-1:0] gated [NUM_INSTR];
  logic [ACC_W-1:0] acc;

  for (genvar g = 0; g < NUM_INSTR; g++) begin : g_gate
    localparam logic [SEL_W-1:0] UNIT = SEL_W'(unitOf(g));
    assign gated[g] = instrHot[g] ? UNIT : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_INSTR; i++) acc = acc + ACC_W'(gated[i]);
  end

  assign aluSel  = acc[SEL_W-1:0];
  assign illegal = ~|instrHot;

  always_comb begin
    p_class_single_r2: assert ($onehot0(NUM_TYPES'(strobes)))
      else $error("more than one class strobe");
    p_hot_single_r6: assert ($onehot0(instrHot))
      else $error("more than one instruction indicator");
    p_hot_needs_class_r6: assert (instrHot == '0 || strobes != '0)
      else $error("indicator raised without a class");
    p_sum_fits_r7: assert (acc[ACC_W-1:SEL_W] == '0)
      else $error("select sum overflows code width");
    p_illegal_zero_sel_r8: assert (!illegal || aluSel == '0)
      else $error("illegal word with nonzero select");
  end

endmodule

// File: rtl/instr_decode.sv
module instr_decode
  import instr_decode_pkg::*;
(
  input  logic [31:0] instr,
  output logic [6:0]  opcode,
  output logic [4:0]  rd,
  output logic [2:0]  funct3,
  output logic [4:0]  rs1,
  output logic [4:0]  rs2,
  output logic [6:0]  funct7,
  output logic [31:0] imm,
  output logic [7:0]  typeVec,
  output logic [29:0] instrHot,
  output logic [3:0]  aluSel,
  output logic        illegal
);

  type_strobes_t strobes;

  instr_decode_fields u_fields (
    .instr   (instr),
    .strobes (strobes),
    .opcode  (opcode),
    .rd      (rd),
    .funct3  (funct3),
    .rs1     (rs1),
    .rs2     (rs2),
    .funct7  (funct7),
    .imm     (imm)
  );

  instr_decode_ctrl u_ctrl (
    .opcode   (opcode),
    .funct3   (funct3),
    .funct7   (funct7),
    .strobes  (strobes),
    .instrHot (instrHot),
    .aluSel   (aluSel),
    .illegal  (illegal)
  );

  assign typeVec = strobes;

endmodule

// File: tb/instr_decode_tb.sv
module instr_decode_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instr = '0;
  logic [6:0]  opcode, funct7;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  funct3;
  logic [31:0] imm;
  logic [7:0]  typeVec;
  logic [29:0] instrHot;
  logic [3:0]  aluSel;
  logic        illegal;

  instr_decode u_dut (
    .instr(instr), .opcode(opcode), .rd(rd), .funct3(funct3), .rs1(rs1),
    .rs2(rs2), .funct7(funct7), .imm(imm), .typeVec(typeVec),
    .instrHot(instrHot), .aluSel(aluSel), .illegal(illegal)
  );

  typedef struct {
    logic [31:0] w;
    logic [29:0] hot;
    logic [3:0]  sel;
    logic [7:0]  typ;
    logic [31:0] imm;
    logic        chkImm;
    logic        ill;
    logic        chkRd, chkRs1, chkRs2;
    logic [4:0]  rd, rs1, rs2;
    string       tagHot;
    string       tagImm;
  } exp_t;

  typedef struct packed {
    logic [6:0] op;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [3:0] unit;
    logic [2:0] cls;
  } desc_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Class indices (R2): 0 reg,1 load,2 imm,3 jalr,4 store,5 branch,6 upper,7 jump.
  function automatic desc_t descOf(input int i);
    case (i)
      0:  return '{7'h33, 3'd0, 7'h00, 4'd0,  3'd0};
      1:  return '{7'h33, 3'd0, 7'h20, 4'd9,  3'd0};
      2:  return '{7'h33, 3'd7, 7'h00, 4'd1,  3'd0};
      3:  return '{7'h33, 3'd6, 7'h00, 4'd2,  3'd0};
      4:  return '{7'h33, 3'd4, 7'h00, 4'd3,  3'd0};
      5:  return '{7'h33, 3'd1, 7'h00, 4'd4,  3'd0};
      6:  return '{7'h33, 3'd5, 7'h00, 4'd5,  3'd0};
      7:  return '{7'h33, 3'd5, 7'h20, 4'd6,  3'd0};
      8:  return '{7'h33, 3'd2, 7'h00, 4'd7,  3'd0};
      9:  return '{7'h33, 3'd3, 7'h00, 4'd8,  3'd0};
      10: return '{7'h13, 3'd0, 7'h00, 4'd0,  3'd2};
      11: return '{7'h13, 3'd7, 7'h00, 4'd1,  3'd2};
      12: return '{7'h13, 3'd6, 7'h00, 4'd2,  3'd2};
      13: return '{7'h13, 3'd4, 7'h00, 4'd3,  3'd2};
      14: return '{7'h13, 3'd1, 7'h00, 4'd4,  3'd2};
      15: return '{7'h13, 3'd5, 7'h00, 4'd5,  3'd2};
      16: return '{7'h13, 3'd5, 7'h20, 4'd6,  3'd2};
      17: return '{7'h13, 3'd2, 7'h00, 4'd7,  3'd2};
      18: return '{7'h13, 3'd3, 7'h00, 4'd8,  3'd2};
      19: return '{7'h03, 3'd0, 7'h00, 4'd0,  3'd1};
      20: return '{7'h03, 3'd1, 7'h00, 4'd0,  3'd1};
      21: return '{7'h03, 3'd2, 7'h00, 4'd0,  3'd1};
      22: return '{7'h67, 3'd0, 7'h00, 4'd0,  3'd3};
      23: return '{7'h23, 3'd0, 7'h00, 4'd0,  3'd4};
      24: return '{7'h23, 3'd1, 7'h00, 4'd0,  3'd4};
      25: return '{7'h23, 3'd2, 7'h00, 4'd0,  3'd4};
      26: return '{7'h63, 3'd0, 7'h00, 4'd11, 3'd5};
      27: return '{7'h63, 3'd1, 7'h00, 4'd12, 3'd5};
      28: return '{7'h37, 3'd0, 7'h00, 4'd10, 3'd6};
      default: return '{7'h6F, 3'd0, 7'h00, 4'd0, 3'd7};
    endcase
  endfunction

  function automatic string hotTag(input int i);
    if (i < 10) return "R3";
    if (i < 19) return "R4";
    return "R5";
  endfunction

  task automatic send(input exp_t e);
    @(posedge clk);
    #1;
    instr = e.w;
    q.push_back(e);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per cycle, samples at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check("R2", "typeVec", {24'b0, typeVec}, {24'b0, e.typ});
        check(e.tagHot, "instrHot", {2'b0, instrHot}, {2'b0, e.hot});
        check("R6", "hot count", $countones(instrHot), e.ill ? 0 : 1);
        check("R7", "aluSel", {28'b0, aluSel}, {28'b0, e.sel});
        check("R8", "illegal", {31'b0, illegal}, {31'b0, e.ill});
        check("R1", "opcode", {25'b0, opcode}, {25'b0, e.w[6:0]});
        if (e.chkRd)  check("R1", "rd",  {27'b0, rd},  {27'b0, e.rd});
        if (e.chkRs1) check("R1", "rs1", {27'b0, rs1}, {27'b0, e.rs1});
        if (e.chkRs2) check("R1", "rs2", {27'b0, rs2}, {27'b0, e.rs2});
        if (e.chkImm) check(e.tagImm, "imm", imm, e.imm);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic exp_t blank(input logic [31:0] w);
    exp_t e;
    e.w = w; e.hot = '0; e.sel = '0; e.typ = '0; e.imm = '0;
    e.chkImm = 1'b0; e.ill = 1'b1;
    e.chkRd = 1'b0; e.chkRs1 = 1'b0; e.chkRs2 = 1'b0;
    e.rd = '0; e.rs1 = '0; e.rs2 = '0;
    e.tagHot = "R8"; e.tagImm = "R11";
    return e;
  endfunction

  function automatic exp_t illegalItem(input logic [31:0] w, input logic [7:0] typ);
    exp_t e;
    e = blank(w);
    e.typ = typ;
    e.chkImm = (typ == 8'h00);
    return e;
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;

    // Reset/idle word: all-zero opcode is unknown (R8, R11).
    begin
      exp_t e;
      e = blank(32'h0);
      e.chkImm = 1'b1;
      send(e);
    end

    for (int i = 0; i < 30; i++) begin
      for (int rep = 0; rep < 4; rep++) begin
        desc_t d;
        exp_t e;
        logic [4:0]  rdv, r1, r2;
        logic [11:0] i12;
        logic [12:0] b13;
        logic [19:0] u20;
        logic [20:0] j21;
        logic [31:0] rnd;
        d = descOf(i);
        rnd = $urandom;
        rdv = 5'($urandom); r1 = 5'($urandom); r2 = 5'($urandom);
        case (rep)
          0: rnd = 32'h8000_0000;
          1: rnd = 32'h7FFF_FFFF;
          default: ;
        endcase
        i12 = rnd[31:20];
        b13 = {rnd[31:20], 1'b0};
        u20 = rnd[31:12];
        j21 = {rnd[31:12], 1'b0};
        e = blank(0);
        e.ill = 1'b0;
        e.hot = 30'b1 << i;
        e.sel = d.unit;
        e.typ = 8'b1 << d.cls;
        e.tagHot = hotTag(i);
        e.chkImm = 1'b1;
        e.rd = rdv; e.rs1 = r1; e.rs2 = r2;
        case (d.cls)
          3'd0: begin
            e.w = {d.f7, r2, r1, d.f3, rdv, d.op};
            e.imm = '0; e.tagImm = "R11";
            e.chkRd = 1; e.chkRs1 = 1; e.chkRs2 = 1;
          end
          3'd1, 3'd2, 3'd3: begin
            if (d.cls == 3'd2 && (d.f3 == 3'd1 || d.f3 == 3'd5))
              i12 = {d.f7, 5'($urandom)};
            e.w = {i12, r1, d.f3, rdv, d.op};
            e.imm = {{20{i12[11]}}, i12}; e.tagImm = "R9";
            e.chkRd = 1; e.chkRs1 = 1;
          end
          3'd4: begin
            e.w = {i12[11:5], r2, r1, d.f3, i12[4:0], d.op};
            e.imm = {{20{i12[11]}}, i12}; e.tagImm = "R9";
            e.chkRs1 = 1; e.chkRs2 = 1;
          end
          3'd5: begin
            e.w = {b13[12], b13[10:5], r2, r1, d.f3, b13[4:1], b13[11], d.op};
            e.imm = {{19{b13[12]}}, b13}; e.tagImm = "R10";
            e.chkRs1 = 1; e.chkRs2 = 1;
          end
          3'd6: begin
            e.w = {u20, rdv, d.op};
            e.imm = {u20, 12'b0}; e.tagImm = "R11";
            e.chkRd = 1;
          end
          default: begin
            e.w = {j21[20], j21[10:1], j21[11], j21[19:12], rdv, d.op};
            e.imm = {{11{j21[20]}}, j21}; e.tagImm = "R10";
            e.chkRd = 1;
          end
        endcase
        send(e);
      end
    end

    // Unsupported words one field away from legal ones (R8); class still set (R2).
    send(illegalItem(32'hFFFF_FFFF, 8'h00));                                 // unknown opcode
    send(illegalItem({7'h01, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33}, 8'h01));        // funct7 0000001
    send(illegalItem({7'h20, 5'd3, 5'd2, 3'd1, 5'd1, 7'h33}, 8'h01));        // alt funct7, funct3 001
    send(illegalItem({7'h20, 5'd3, 5'd2, 3'd1, 5'd1, 7'h13}, 8'h04));        // slli with alt funct7
    send(illegalItem({7'h40, 5'd3, 5'd2, 3'd5, 5'd1, 7'h13}, 8'h04));        // shift funct7 1000000
    send(illegalItem({12'h004, 5'd2, 3'd3, 5'd1, 7'h03}, 8'h02));            // load funct3 011
    send(illegalItem({12'h004, 5'd2, 3'd1, 5'd1, 7'h67}, 8'h08));            // jalr funct3 001
    send(illegalItem({7'h00, 5'd3, 5'd2, 3'd3, 5'd1, 7'h23}, 8'h10));        // store funct3 011
    send(illegalItem({7'h00, 5'd3, 5'd2, 3'd4, 5'd1, 7'h63}, 8'h20));        // branch funct3 100
    send(illegalItem({25'h155_5555, 7'h17}, 8'h00));                         // unsupported opcode

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule